// File: doc/BRIEF.md
# Transmit Frame Length and CRC Sequencer

This block turns a byte FIFO's contents into a serial bit stream for a downstream symbol encoder. A command is accepted only when the block is idle. At that moment it captures a 12-bit whole-byte count, a flag for a trailing incomplete byte, and the number of bits to send from that byte. It then announces the frame with a one-cycle start strobe and sends one bit per clock, most significant bit first, popping one FIFO entry for each byte it starts.

Two qualifiers travel with the command strobe. One selects whether an inverted CRC-16 is appended after the payload. The other selects whether the start is held back. A held-back start waits for a number of prescaled ticks, taken from an 8-bit wait value. A one-cycle interrupt pulse marks the end of the frame, after which the block is idle again. The FIFO is read in show-ahead fashion: the head byte is presented on `fifo_data_i`, and `fifo_rd_o` removes it at the next clock edge.

Top module: `txframe_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a command arrives, `sof_o`, `bit_vld_o`, `done_irq_o` and `fifo_rd_o` are all low.
- R2: A frame carries 8×W payload bits plus P bits, where:
  - W = {`len_a_i`[7:0], `len_b_i`[7:4]} is the whole-byte count.
  - P = `len_b_i`[3:1] when `len_b_i`[0] is 1, and 0 otherwise. With the flag set and P = 0, no extra byte is read.
  - The block pops exactly one FIFO entry per byte it sends from, whole or partial.
- R3: Payload bits leave most significant bit first. The partial byte sends only its upper P bits.
- R4: With `cmd_crc_i` high at the command, 16 bits follow the payload. They are the bitwise inverse of CRC-16 (polynomial 0x1021, preset 0xFFFF) over the payload bits, sent most significant bit first. The nine ASCII bytes "123456789" yield the 16 bits 0xD64E.
- R5: With `cmd_crc_i` low, nothing is appended and the frame ends after the last payload bit.
- R6: `sof_o` is high for exactly one cycle per frame, in the cycle directly before the first bit. For an undelayed command it is the cycle right after the command edge.
- R7: With `cmd_dly_i` high and a wait value N > 0, `sof_o` rises right after the clock edge that samples the N-th `tick_i` pulse following the command. With N = 0 the start is undelayed.
- R8: `done_irq_o` is a single-cycle pulse in the cycle after the last bit (or after `sof_o` for an empty frame), and the block is then idle.
- R9: A command strobe while a frame is in progress is ignored. Changes to the length, wait and qualifier inputs after the command do not affect the frame in progress.
- R10: Within a frame, `bit_vld_o` is high in consecutive cycles with no gap, from the first payload bit through the last CRC bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| len_a_i | input | 8 | Upper eight bits of the whole-byte count |
| len_b_i | input | 8 | [7:4] low count nibble, [3:1] partial bit count, [0] partial flag |
| wait_i | input | 8 | Start delay in ticks for delayed commands |
| tick_i | input | 1 | Prescaled tick for the start delay |
| cmd_go_i | input | 1 | Command strobe |
| cmd_crc_i | input | 1 | Append CRC (sampled with strobe) |
| cmd_dly_i | input | 1 | Delay the start (sampled with strobe) |
| fifo_data_i | input | 8 | FIFO head byte (show-ahead) |
| fifo_rd_o | output | 1 | Pop the FIFO head at the next edge |
| bit_o | output | 1 | Serial bit |
| bit_vld_o | output | 1 | `bit_o` is valid this cycle |
| sof_o | output | 1 | Frame-start strobe |
| done_irq_o | output | 1 | Frame-complete interrupt pulse |

## Verification
The timing of each output is fixed relative to the command:
- `sof_o` is due one register stage after the command edge, or one stage after the edge that samples the last wait tick.
- The k-th bit follows `sof_o` by k cycles.
- `done_irq_o` comes one cycle after the last bit.

Every cycle is sampled 1 ns after the falling clock edge and numbered from the command edge. The bench checks the cycle of each event against those offsets. It also compares the collected bit string with one it builds from the FIFO contents and a CRC model of its own. For delayed starts, it counts the ticks it drove before `sof_o` was seen and compares that count with the wait value.

// File: rtl/txf_pkg.sv
package txf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_WAIT = 3'd1,
      ST_SOF  = 3'd2,
      ST_DATA = 3'd3,
      ST_CRC  = 3'd4,
      ST_DONE = 3'd5
   } txf_state_e;

endpackage

// File: rtl/txf_len_dec.sv
module txf_len_dec #(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 12,
   parameter int RES_W  = 3,
   localparam int BCNT_W = CNT_W + 1
) (
   input  logic [BYTE_W-1:0] len_a_i,
   input  logic [BYTE_W-1:0] len_b_i,
   output logic [BCNT_W-1:0] bytes_o,
   output logic              part_o,
   output logic [RES_W-1:0]  resid_o
);

   logic [CNT_W-1:0] whole;

   generate
      if (CNT_W != BYTE_W + 4) begin : g_bad_cnt
         $error("txf_len_dec: CNT_W must equal BYTE_W + 4");
      end
      if (RES_W + 1 > 4) begin : g_bad_res
         $error("txf_len_dec: residual field must fit bits 3:1");
      end
   endgenerate

   always_comb begin
      whole   = {len_a_i, len_b_i[BYTE_W-1:BYTE_W-4]};
      resid_o = len_b_i[RES_W:1];
      part_o  = len_b_i[0] && (resid_o != '0);
      bytes_o = BCNT_W'(whole) + BCNT_W'(part_o);
   end

endmodule

// File: rtl/txf_crc.sv
module txf_crc #(
   parameter int          W    = 16,
   parameter logic [W-1:0] POLY = 16'h1021,
   parameter logic [W-1:0] INIT = 16'hFFFF,
   parameter bit          INV  = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         init_i,
   input  logic         en_i,
   input  logic         din_i,
   output logic [W-1:0] crc_o
);

   logic [W-1:0] crc_q;
   logic         fb;

   assign fb = crc_q[W-1] ^ din_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      crc_q <= INIT;
      else if (init_i)  crc_q <= INIT;
      else if (en_i)    crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   generate
      if (INV) begin : g_inv
         assign crc_o = ~crc_q;
      end else begin : g_plain
         assign crc_o = crc_q;
      end
   endgenerate

   // R4: the register only moves when seeded or fed a payload bit
   a_r4_crc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!init_i && !en_i) |=> $stable(crc_q));

endmodule

// File: rtl/txf_wait_tmr.sv
module txf_wait_tmr #(
   parameter int DLY_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [DLY_W-1:0] limit_i,
   input  logic             tick_i,
   output logic             fire_o
);

   logic [DLY_W-1:0] cnt_q;

   generate
      if (DLY_W < 1) begin : g_bad_w
         $error("txf_wait_tmr: DLY_W must be at least 1");
      end
   endgenerate

   assign fire_o = tick_i && (cnt_q == DLY_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     cnt_q <= '0;
      else if (start_i)                cnt_q <= limit_i;
      else if (tick_i && cnt_q != '0)  cnt_q <= cnt_q - DLY_W'(1);
   end

   // R7: the count changes only on a start or a tick
   a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!start_i && !tick_i) |=> $stable(cnt_q));
   // R7: the wait ends once per start
   a_r7_fire_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fire_o && !start_i) |=> !fire_o);

endmodule

// File: rtl/txframe_seq.sv
module txframe_seq #(
   parameter int           CNT_W    = 12,
   parameter int           RES_W    = 3,
   parameter int           DLY_W    = 8,
   parameter int           CRC_W    = 16,
   parameter logic [15:0]  CRC_POLY = 16'h1021,
   parameter logic [15:0]  CRC_INIT = 16'hFFFF,
   parameter bit           CRC_INV  = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [7:0]       len_a_i,
   input  logic [7:0]       len_b_i,
   input  logic [DLY_W-1:0] wait_i,
   input  logic             tick_i,
   input  logic             cmd_go_i,
   input  logic             cmd_crc_i,
   input  logic             cmd_dly_i,
   input  logic [7:0]       fifo_data_i,
   output logic             fifo_rd_o,
   output logic             bit_o,
   output logic             bit_vld_o,
   output logic             sof_o,
   output logic             done_irq_o
);
   import txf_pkg::*;

   localparam int BYTE_W = 1 << RES_W;
   localparam int BCNT_W = CNT_W + 1;
   localparam int BPOS_W = RES_W + 1;
   localparam int CIDX_W = $clog2(CRC_W);
   localparam logic [CIDX_W-1:0] CTOP = CIDX_W'(CRC_W - 1);

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("txframe_seq: RES_W must give 8-bit bytes");
      end
      if (CRC_W != 16) begin : g_bad_crc
         $error("txframe_seq: CRC_W must be 16");
      end
   endgenerate

   txf_state_e         state_q;
   logic [BCNT_W-1:0]  bcnt_q;
   logic [BPOS_W-1:0]  bpos_q;
   logic [CIDX_W-1:0]  cidx_q;
   logic [BYTE_W-1:0]  shreg_q;
   logic               part_q;
   logic [RES_W-1:0]   resid_q;
   logic               crc_en_q;

   logic [BCNT_W-1:0]  dec_bytes;
   logic               dec_part;
   logic [RES_W-1:0]   dec_resid;
   logic               accept, first, last_bit, tmr_fire;
   logic [BPOS_W-1:0]  cur_w;
   logic [CRC_W-1:0]   crc_val;

   txf_len_dec #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .RES_W(RES_W)) u_len (
      .len_a_i (len_a_i),
      .len_b_i (len_b_i),
      .bytes_o (dec_bytes),
      .part_o  (dec_part),
      .resid_o (dec_resid)
   );

   txf_wait_tmr #(.DLY_W(DLY_W)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (accept && cmd_dly_i),
      .limit_i (wait_i),
      .tick_i  (tick_i),
      .fire_o  (tmr_fire)
   );

   txf_crc #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT), .INV(CRC_INV)) u_crc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .init_i (accept),
      .en_i   (state_q == ST_DATA),
      .din_i  (bit_o),
      .crc_o  (crc_val)
   );

   always_comb begin
      accept    = (state_q == ST_IDLE) && cmd_go_i;
      first     = (bpos_q == '0);
      cur_w     = (bcnt_q == BCNT_W'(1) && part_q) ? {1'b0, resid_q} : BPOS_W'(BYTE_W);
      last_bit  = (bpos_q + BPOS_W'(1)) == cur_w;
      fifo_rd_o = (state_q == ST_DATA) && first;
      bit_vld_o = (state_q == ST_DATA) || (state_q == ST_CRC);
      sof_o     = (state_q == ST_SOF);
      done_irq_o = (state_q == ST_DONE);
      unique case (state_q)
         ST_DATA: bit_o = first ? fifo_data_i[BYTE_W-1] : shreg_q[BYTE_W-1];
         ST_CRC:  bit_o = crc_val[CTOP - cidx_q];
         default: bit_o = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= ST_IDLE;
         bcnt_q   <= '0;
         bpos_q   <= '0;
         cidx_q   <= '0;
         shreg_q  <= '0;
         part_q   <= 1'b0;
         resid_q  <= '0;
         crc_en_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               bcnt_q   <= dec_bytes;
               part_q   <= dec_part;
               resid_q  <= dec_resid;
               crc_en_q <= cmd_crc_i;
               bpos_q   <= '0;
               cidx_q   <= '0;
               state_q  <= (cmd_dly_i && wait_i != '0) ? ST_WAIT : ST_SOF;
            end
            ST_WAIT: if (tmr_fire) state_q <= ST_SOF;
            ST_SOF: begin
               if (bcnt_q != '0) state_q <= ST_DATA;
               else              state_q <= crc_en_q ? ST_CRC : ST_DONE;
            end
            ST_DATA: begin
               shreg_q <= first ? {fifo_data_i[BYTE_W-2:0], 1'b0}
                                : {shreg_q[BYTE_W-2:0], 1'b0};
               if (last_bit) begin
                  bpos_q <= '0;
                  bcnt_q <= bcnt_q - BCNT_W'(1);
                  if (bcnt_q == BCNT_W'(1)) state_q <= crc_en_q ? ST_CRC : ST_DONE;
               end else begin
                  bpos_q <= bpos_q + BPOS_W'(1);
               end
            end
            ST_CRC: begin
               cidx_q <= cidx_q + CIDX_W'(1);
               if (cidx_q == CTOP) state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R8: start, bit and done strobes never overlap
   a_r8_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({sof_o, bit_vld_o, done_irq_o}));
   // R8: after the interrupt the block is quiet
   a_r8_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_irq_o |=> !(sof_o || bit_vld_o || done_irq_o));
   // R2: FIFO pops only happen while a bit goes out
   a_r2_pop_with_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fifo_rd_o |-> bit_vld_o);
   // R6: the start strobe is followed by a bit or the end
   a_r6_sof_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sof_o |=> (bit_vld_o || done_irq_o));
   // R10: the bit stream ends only into the interrupt
   a_r10_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_vld_o |=> (bit_vld_o || done_irq_o));

endmodule

// File: tb/txframe_seq_tb.sv
`timescale 1ns/1ps
module txframe_seq_tb;

   typedef struct packed {
      logic [7:0] hi;
      logic [7:0] lo;
      logic       crc;
      logic       dly;
      logic [7:0] wt;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      vec_t'{8'h00, 8'h30, 1'b1, 1'b0, 8'd0},   // 3 bytes with CRC
      vec_t'{8'h00, 8'h21, 1'b0, 1'b0, 8'd0},   // flag set, 0 residual bits
      vec_t'{8'h00, 8'h1B, 1'b1, 1'b0, 8'd0},   // 1 byte + 5 bits
      vec_t'{8'h00, 8'h0F, 1'b0, 1'b0, 8'd0},   // 7 bits only
      vec_t'{8'h00, 8'h00, 1'b1, 1'b0, 8'd0},   // empty, CRC only
      vec_t'{8'h00, 8'h00, 1'b0, 1'b0, 8'd0},   // empty, nothing
      vec_t'{8'h01, 8'h05, 1'b1, 1'b1, 8'd3},   // 16 bytes + 2 bits, delay 3
      vec_t'{8'h10, 8'h10, 1'b1, 1'b1, 8'd0},   // 257 bytes, delay 0
      vec_t'{8'h00, 8'h40, 1'b0, 1'b1, 8'd1}    // 4 bytes, delay 1
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] len_a = '0, len_b = '0, wait_v = '0;
   logic       tick = 1'b0, go = 1'b0, crc_q = 1'b0, dly_q = 1'b0;
   logic [7:0] mem [0:511];
   logic [9:0] ptr = '0;
   logic [7:0] fifo_data;
   logic       fifo_rd, bit_s, bit_vld, sof, done_irq;

   int n_chk = 0, n_fail = 0;
   logic cap [0:4199];
   logic exb [0:4199];
   int ncap, nexp, sof_c, done_c, first_c, last_c, nsof, ndone, gaps, tick_at;

   assign fifo_data = mem[ptr[8:0]];
   always #2.5 clk = ~clk;

   txframe_seq u_dut (
      .clk_i(clk), .rst_ni(rst_n), .len_a_i(len_a), .len_b_i(len_b),
      .wait_i(wait_v), .tick_i(tick), .cmd_go_i(go), .cmd_crc_i(crc_q),
      .cmd_dly_i(dly_q), .fifo_data_i(fifo_data), .fifo_rd_o(fifo_rd),
      .bit_o(bit_s), .bit_vld_o(bit_vld), .sof_o(sof), .done_irq_o(done_irq)
   );

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic build_exp(input vec_t v);
      int whole, pops, res;
      bit part;
      logic [15:0] c;
      whole = {v.hi, v.lo[7:4]};
      res   = int'(v.lo[3:1]);
      part  = v.lo[0] && res != 0;
      pops  = whole + (part ? 1 : 0);
      nexp  = 0;
      for (int b = 0; b < pops; b++) begin
         int w = (part && b == pops - 1) ? res : 8;
         for (int k = 0; k < w; k++) begin
            exb[nexp] = mem[b][7-k];
            nexp++;
         end
      end
      if (v.crc) begin
         c = 16'hFFFF;
         for (int i = 0; i < nexp; i++) begin
            logic fb = c[15] ^ exb[i];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
         end
         c = ~c;
         for (int k = 15; k >= 0; k--) begin
            exb[nexp] = c[k];
            nexp++;
         end
      end
   endtask

   task automatic run_frame(input vec_t v, input bit poke);
      bit rd_prev = 1'b0, sof_seen = 1'b0, fin = 1'b0;
      int ticks = 0;
      ncap = 0; nsof = 0; ndone = 0; gaps = 0; tick_at = -1;
      sof_c = -1; done_c = -1; first_c = -1; last_c = -1;
      @(negedge clk);
      ptr = '0;
      len_a = v.hi; len_b = v.lo; wait_v = v.wt;
      crc_q = v.crc; dly_q = v.dly; go = 1'b1; tick = 1'b0;
      @(negedge clk);
      go = 1'b0;
      for (int c = 0; c < 6000 && !fin; c++) begin
         if (c > 0) begin
            @(negedge clk);
            if (rd_prev) ptr = ptr + 10'd1;
         end
         #1;
         if (sof) begin
            nsof++; sof_c = c;
            if (!sof_seen) begin sof_seen = 1'b1; tick_at = ticks; end
         end
         if (bit_vld) begin
            if (ncap == 0) first_c = c;
            else if (c != last_c + 1) gaps++;
            cap[ncap] = bit_s; ncap++; last_c = c;
         end
         if (done_irq) begin ndone++; done_c = c; end
         rd_prev = fifo_rd;
         tick = v.dly && !sof_seen && (c % 3 == 1);
         if (tick) ticks++;
         if (poke && c == 10) begin
            go = 1'b1; crc_q = 1'b1; dly_q = 1'b1; len_b = 8'h80; wait_v = 8'd9;
         end else go = 1'b0;
         if (ndone > 0 && c >= done_c + 3) fin = 1'b1;
      end
      tick = 1'b0; go = 1'b0;
      if (!fin) check(1'b0, "watchdog frame timeout", 0, 1);
   endtask

   task automatic check_frame(input vec_t v);
      int mism = 0, at = -1, pops;
      bit part = v.lo[0] && v.lo[3:1] != 3'd0;
      pops = int'({v.hi, v.lo[7:4]}) + (part ? 1 : 0);
      build_exp(v);
      check(nsof == 1, "R6 single start strobe", nsof, 1);
      if (v.dly && v.wt != 0) check(tick_at == int'(v.wt), "R7 ticks before start", tick_at, int'(v.wt));
      else check(sof_c == 0, "R6 start cycle after command", sof_c, 0);
      check(ncap == nexp, v.crc ? "R2 R4 bit count" : "R2 R5 bit count", ncap, nexp);
      for (int i = 0; i < ncap && i < nexp; i++)
         if (cap[i] !== exb[i]) begin mism++; if (at < 0) at = i; end
      check(mism == 0, "R3 R4 bit content first bad index", at, -1);
      check(ndone == 1 && done_c == ((ncap > 0) ? last_c : sof_c) + 1,
            "R8 done cycle", done_c, ((ncap > 0) ? last_c : sof_c) + 1);
      check(int'(ptr) == pops, "R2 FIFO pops", int'(ptr), pops);
      check(gaps == 0 && (ncap == 0 || first_c == sof_c + 1), "R10 contiguous bits", gaps, 0);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] tail;
      for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 5);
      repeat (3) @(negedge clk);
      check({sof, bit_vld, done_irq, fifo_rd} == 4'b0, "R1 outputs in reset",
            int'({sof, bit_vld, done_irq, fifo_rd}), 0);
      rst_n = 1'b1;
      repeat (5) begin
         @(negedge clk);
         check({sof, bit_vld, done_irq, fifo_rd} == 4'b0, "R1 idle after reset",
               int'({sof, bit_vld, done_irq, fifo_rd}), 0);
      end

      for (int n = 0; n < NV; n++) begin
         for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + n * 11 + 5);
         run_frame(VEC[n], 1'b0);
         check_frame(VEC[n]);
      end

      // R4 known answer: "123456789" -> D64E
      mem[0] = 8'h31; mem[1] = 8'h32; mem[2] = 8'h33; mem[3] = 8'h34; mem[4] = 8'h35;
      mem[5] = 8'h36; mem[6] = 8'h37; mem[7] = 8'h38; mem[8] = 8'h39;
      run_frame(vec_t'{8'h00, 8'h90, 1'b1, 1'b0, 8'd0}, 1'b0);
      for (int k = 0; k < 16; k++) tail[15-k] = cap[72 + k];
      check(ncap == 88 && tail == 16'hD64E, "R4 known CRC value", int'(tail), 16'hD64E);

      // R9 command and length changes mid-frame are ignored
      for (int i = 0; i < 512; i++) mem[i] = 8'(i * 91 + 3);
      run_frame(vec_t'{8'h00, 8'h50, 1'b0, 1'b0, 8'd0}, 1'b1);
      check(ncap == 40 && nsof == 1 && ndone == 1, "R9 busy command ignored", ncap, 40);
      check_frame(vec_t'{8'h00, 8'h50, 1'b0, 1'b0, 8'd0});
      repeat (12) begin
         @(negedge clk);
         check(!sof && !bit_vld, "R9 no late frame start", int'(sof), 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule